// File: doc/BRIEF.md
# Clock Source Mode Arbiter

This block decides which operating mode a clock generator is in. Software writes a requested mode code, a reference-select bit, a loop multiplier field and an output divider exponent through a single write strobe. The block keeps the requested code in a register. It reports the mode actually in force as a separate status code. That status moves towards the request only when the readiness flags allow it. The flags are: the external reference is running, the loop output is stable, and no loss of clock has been seen.

Each status change passes through a fixed four-stage synchroniser, so the status always lags the request and can stay different from it for as long as a flag stays low. The reference-select bit is captured on the first write after reset and cannot be changed after that. When it is captured as 0, the external oscillator stays disabled and external readiness is ignored until the next reset. The block also produces the divider exponent for the generated output clock. It adds one extra halving while the loop is in a mode that uses it and has not yet locked, or is relocking after a multiplier change.

Top module: `clk_mode_arbiter`

## Requirements
- R1: After reset the requested code is 00, the status is 00, the reason is 00, the oscillator enable is 0 and the divider exponent is 0. After that, the requested code always shows the value of the last write.
- R2: When the conditions for a new target mode become true before clock edge N, the status shows that target after edge N+3. It is visible at the fourth clock edge counted from and including edge N, and not earlier.
- R3: The target for request 10 (bypass on external reference) is 10 when external readiness is effective, and 00 when it is not.
- R4: For request 11 (loop on external reference), the target is chosen in this order. It is 00 when external readiness is not effective. Otherwise it is 00 when loss of clock is flagged. Otherwise it is 10 when the loop output is not stable. Otherwise it is 11.
- R5: For request 01 (loop on internal reference), the target is 00 when loss of clock is flagged or the loop is not stable, and 01 otherwise. Request 00 always targets 00.
- R6: The reference-select bit is captured only by the first write after reset, and the oscillator enable output shows the captured value. External readiness counts as effective only when the captured bit is 1.
- R7: The divider exponent equals the written divider field, plus one when both of these hold: the status is 01 or 11, and a relock is pending. A relock becomes pending at reset and on any write whose multiplier field differs from the stored one. It is cleared in a cycle where the loop-locked flag is 1 and no such write occurs.
- R8: The reason output is 00 when the request equals the status, and also while a reachable target is still in transit. Otherwise it gives the blocking cause: 01 external reference not ready, 10 loop not stable, 11 loss of clock. The precedence is the same as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control register write strobe |
| wrReq | input | 2 | Requested mode code to write |
| wrRefSel | input | 1 | Reference-select bit to write (kept only on first write) |
| wrMult | input | MULT_W | Loop multiplier field to write |
| wrRdiv | input | RDIV_W | Output divider exponent to write |
| extReady | input | 1 | External reference running stably |
| loopStable | input | 1 | Loop output stable |
| clkLoss | input | 1 | Loss of clock seen |
| loopLocked | input | 1 | Loop has reached lock |
| reqMode | output | 2 | Stored requested mode |
| actMode | output | 2 | Mode actually in force |
| reason | output | 2 | Cause of request/status mismatch |
| oscEnable | output | 1 | External oscillator amplifier enable |
| divExp | output | RDIV_W+1 | Output clock divider exponent |

## Verification
The assertions assume that every readiness flag is already synchronous to `clk`. The gating checks look back exactly four edges at the flags, so an asynchronous glitch would break that link. The stimulus changes flags and write fields only on the falling edge. It holds each flag level for several cycles, and it clears loopLocked before a multiplier change so that the relock is seen for at least one cycle. The reference-select capture is exercised across two resets, once with each first-write value.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic [1:0] {
    MODE_SAFE     = 2'b00,
    MODE_LOOP_INT = 2'b01,
    MODE_BYPASS   = 2'b10,
    MODE_LOOP_EXT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    WHY_NONE = 2'b00,
    WHY_REF  = 2'b01,
    WHY_LOOP = 2'b10,
    WHY_LOSS = 2'b11
  } why_e;

  // Depth of the status synchroniser; fixed by the block's timing contract.
  localparam int SYNC_STAGES = 4;

  typedef struct packed {
    logic loadReq;
    logic loadRef;
    logic loadDiv;
    logic armRelock;
    logic clearRelock;
  } regStrobe_t;

endpackage

// File: rtl/cma_regs.sv
module cma_regs
  import clkmode_pkg::*;
#(
  parameter int MULT_W = 3,
  parameter int RDIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [1:0]        wrReq,
  input  logic              wrRefSel,
  input  logic [MULT_W-1:0] wrMult,
  input  logic [RDIV_W-1:0] wrRdiv,
  output mode_e             reqMode,
  output logic              refSel,
  output logic              written,
  output logic [MULT_W-1:0] multVal,
  output logic [RDIV_W-1:0] rdivVal,
  output logic              relockPend
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMode <= MODE_SAFE;
    end else if (stb.loadReq) begin
      reqMode <= mode_e'(wrReq);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel  <= 1'b0;
      written <= 1'b0;
    end else if (stb.loadRef) begin
      refSel  <= wrRefSel;
      written <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      multVal <= '0;
      rdivVal <= '0;
    end else if (stb.loadDiv) begin
      multVal <= wrMult;
      rdivVal <= wrRdiv;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relockPend <= 1'b1;
    end else if (stb.armRelock) begin
      relockPend <= 1'b1;
    end else if (stb.clearRelock) begin
      relockPend <= 1'b0;
    end
  end

  // R6
  ref_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(written) |-> $stable(refSel));

endmodule

// File: rtl/cma_ctrl.sv
module cma_ctrl
  import clkmode_pkg::*;
#(
  parameter int MULT_W = 3,
  parameter int RDIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [MULT_W-1:0] wrMult,
  input  mode_e             reqMode,
  input  logic              refSel,
  input  logic              written,
  input  logic [MULT_W-1:0] multVal,
  input  logic [RDIV_W-1:0] rdivVal,
  input  logic              relockPend,
  input  logic              extReady,
  input  logic              loopStable,
  input  logic              clkLoss,
  input  logic              loopLocked,
  output regStrobe_t        stb,
  output mode_e             actMode,
  output why_e              reason,
  output logic [RDIV_W:0]   divExp
);

  logic  extOk;
  mode_e goal;
  why_e  gateWhy;
  mode_e stage [SYNC_STAGES];
  logic  actLoop;

  // Strobes towards the register datapath
  always_comb begin
    stb.loadReq     = wrEn;
    stb.loadRef     = wrEn && !written;
    stb.loadDiv     = wrEn;
    stb.armRelock   = wrEn && (wrMult != multVal);
    stb.clearRelock = loopLocked && !stb.armRelock;
  end

  // Target selection with blocking cause
  always_comb begin
    extOk   = extReady && refSel;
    goal    = MODE_SAFE;
    gateWhy = WHY_NONE;
    unique case (reqMode)
      MODE_BYPASS: begin
        if (extOk) goal = MODE_BYPASS;
        else       gateWhy = WHY_REF;
      end
      MODE_LOOP_EXT: begin
        if (!extOk) begin
          gateWhy = WHY_REF;
        end else if (clkLoss) begin
          gateWhy = WHY_LOSS;
        end else if (!loopStable) begin
          goal    = MODE_BYPASS;
          gateWhy = WHY_LOOP;
        end else begin
          goal = MODE_LOOP_EXT;
        end
      end
      MODE_LOOP_INT: begin
        if (clkLoss)          gateWhy = WHY_LOSS;
        else if (!loopStable) gateWhy = WHY_LOOP;
        else                  goal = MODE_LOOP_INT;
      end
      default: goal = MODE_SAFE;
    endcase
  end

  // Status synchroniser
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= MODE_SAFE;
        else       stage[i] <= goal;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= MODE_SAFE;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign actMode = stage[SYNC_STAGES-1];
  assign reason  = (reqMode == actMode) ? WHY_NONE : gateWhy;
  assign actLoop = (actMode == MODE_LOOP_INT) || (actMode == MODE_LOOP_EXT);
  assign divExp  = {1'b0, rdivVal} + {{RDIV_W{1'b0}}, actLoop && relockPend};

  // R3
  bypass_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_BYPASS) |-> $past(extOk, SYNC_STAGES));

  // R4
  loop_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_LOOP_EXT) |->
      ($past(extOk, SYNC_STAGES) && $past(loopStable, SYNC_STAGES)
       && !$past(clkLoss, SYNC_STAGES)));

  // R5
  loop_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actMode == MODE_LOOP_INT) |->
      ($past(loopStable, SYNC_STAGES) && !$past(clkLoss, SYNC_STAGES)));

  // R7
  relock_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrMult != multVal)) |=> relockPend);

endmodule

// File: rtl/clk_mode_arbiter.sv
module clk_mode_arbiter
  import clkmode_pkg::*;
#(
  parameter int MULT_W = 3,
  parameter int RDIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrReq,
  input  logic              wrRefSel,
  input  logic [MULT_W-1:0] wrMult,
  input  logic [RDIV_W-1:0] wrRdiv,
  input  logic              extReady,
  input  logic              loopStable,
  input  logic              clkLoss,
  input  logic              loopLocked,
  output logic [1:0]        reqMode,
  output logic [1:0]        actMode,
  output logic [1:0]        reason,
  output logic              oscEnable,
  output logic [RDIV_W:0]   divExp
);

  regStrobe_t        stb;
  mode_e             reqQ;
  mode_e             actQ;
  why_e              whyQ;
  logic              refSel;
  logic              written;
  logic [MULT_W-1:0] multVal;
  logic [RDIV_W-1:0] rdivVal;
  logic              relockPend;

  cma_regs #(.MULT_W(MULT_W), .RDIV_W(RDIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrReq(wrReq), .wrRefSel(wrRefSel), .wrMult(wrMult), .wrRdiv(wrRdiv),
    .reqMode(reqQ), .refSel(refSel), .written(written),
    .multVal(multVal), .rdivVal(rdivVal), .relockPend(relockPend)
  );

  cma_ctrl #(.MULT_W(MULT_W), .RDIV_W(RDIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMult(wrMult),
    .reqMode(reqQ), .refSel(refSel), .written(written),
    .multVal(multVal), .rdivVal(rdivVal), .relockPend(relockPend),
    .extReady(extReady), .loopStable(loopStable), .clkLoss(clkLoss),
    .loopLocked(loopLocked),
    .stb(stb), .actMode(actQ), .reason(whyQ), .divExp(divExp)
  );

  assign reqMode   = reqQ;
  assign actMode   = actQ;
  assign reason    = whyQ;
  assign oscEnable = refSel;

endmodule

// File: tb/sim_clk_mode_arbiter.sv
`timescale 1ns/1ps
module sim_clk_mode_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrReq = 2'd0;
  logic       wrRefSel = 1'b0;
  logic [2:0] wrMult = 3'd0;
  logic [2:0] wrRdiv = 3'd0;
  logic       extReady = 1'b0;
  logic       loopStable = 1'b0;
  logic       clkLoss = 1'b0;
  logic       loopLocked = 1'b0;
  logic [1:0] reqMode;
  logic [1:0] actMode;
  logic [1:0] reason;
  logic       oscEnable;
  logic [3:0] divExp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  int mReq = 0, mRef = 0, mWritten = 0, mMult = 0, mRdiv = 0, mRelock = 1, mAct = 0;
  int pq[$] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  clk_mode_arbiter u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrReq(wrReq), .wrRefSel(wrRefSel),
    .wrMult(wrMult), .wrRdiv(wrRdiv), .extReady(extReady), .loopStable(loopStable),
    .clkLoss(clkLoss), .loopLocked(loopLocked), .reqMode(reqMode), .actMode(actMode),
    .reason(reason), .oscEnable(oscEnable), .divExp(divExp)
  );

  function automatic int goalOf(int r, bit ext, bit st, bit loss);
    case (r)
      2: return ext ? 2 : 0;
      3: begin
        if (!ext) return 0;
        if (loss) return 0;
        return st ? 3 : 2;
      end
      1: return (loss || !st) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  function automatic int whyOf(int r, int a, bit ext, bit st, bit loss);
    if (r == a) return 0;
    if (goalOf(r, ext, st, loss) == r) return 0;
    case (r)
      2: return 1;
      3: begin
        if (!ext) return 1;
        if (loss) return 3;
        return 2;
      end
      1: return loss ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: update the model at the rising edge, compare at the falling edge
  task automatic step();
    bit ext;
    int g;
    @(posedge clk);
    ext = extReady && (mRef == 1);
    if (!rstN) begin
      mReq = 0; mRef = 0; mWritten = 0; mMult = 0; mRdiv = 0; mRelock = 1; mAct = 0;
      pq = '{0, 0, 0, 0};
    end else begin
      g = goalOf(mReq, ext, loopStable, clkLoss);
      pq.push_front(g);
      void'(pq.pop_back());
      mAct = pq[3];
      if (wrEn && (int'(wrMult) != mMult)) mRelock = 1;
      else if (loopLocked) mRelock = 0;
      if (wrEn) begin
        mReq = int'(wrReq);
        mMult = int'(wrMult);
        mRdiv = int'(wrRdiv);
        if (mWritten == 0) begin
          mRef = int'(wrRefSel);
          mWritten = 1;
        end
      end
    end
    @(negedge clk);
    ext = extReady && (mRef == 1);
    check("R1 reqMode", int'(reqMode), mReq);
    check("R2 actMode", int'(actMode), mAct);
    check("R8 reason", int'(reason), whyOf(mReq, mAct, ext, loopStable, clkLoss));
    check("R6 oscEnable", int'(oscEnable), mRef);
    check("R7 divExp", int'(divExp),
          mRdiv + (((mAct == 1) || (mAct == 3)) && (mRelock == 1) ? 1 : 0));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int r, bit rs, int m, int d);
    wrEn = 1'b1; wrReq = 2'(r); wrRefSel = rs; wrMult = 3'(m); wrRdiv = 3'(d);
    step();
    wrEn = 1'b0;
  endtask

  initial begin
    steps(3);
    rstN = 1'b1;
    step();
    check("R1 reset req", int'(reqMode), 0);
    check("R1 reset act", int'(actMode), 0);
    check("R1 reset reason", int'(reason), 0);
    check("R1 reset osc", int'(oscEnable), 0);
    check("R1 reset div", int'(divExp), 0);

    // Bypass blocked by missing reference
    wr(2, 1'b1, 1, 2);
    steps(6);
    check("R3 bypass blocked", int'(actMode), 0);
    check("R8 ref reason", int'(reason), 1);

    // Reference becomes ready: four-edge lag
    extReady = 1'b1;
    steps(3);
    check("R2 still lagging", int'(actMode), 0);
    step();
    check("R2 arrived", int'(actMode), 2);
    check("R3 bypass granted", int'(actMode), 2);

    // Loop on external reference, loop not stable
    wr(3, 1'b1, 1, 2);
    steps(6);
    check("R4 held at bypass", int'(actMode), 2);
    check("R8 loop reason", int'(reason), 2);
    loopStable = 1'b1;
    steps(4);
    check("R4 loop ext granted", int'(actMode), 3);
    check("R7 initial lock halving", int'(divExp), 3);
    loopLocked = 1'b1;
    step();
    loopLocked = 1'b0;
    step();
    check("R7 locked", int'(divExp), 2);

    // Multiplier change rearms relock
    wr(3, 1'b1, 5, 2);
    check("R7 relock armed", int'(divExp), 3);
    loopLocked = 1'b1;
    steps(2);
    check("R7 relock cleared", int'(divExp), 2);

    // Loss of clock forces fallback
    clkLoss = 1'b1;
    steps(4);
    check("R4 loss fallback", int'(actMode), 0);
    check("R8 loss reason", int'(reason), 3);

    // Loop on internal reference
    wr(1, 1'b1, 5, 2);
    steps(5);
    check("R5 loss blocks", int'(actMode), 0);
    check("R8 loss reason int", int'(reason), 3);
    clkLoss = 1'b0;
    loopStable = 1'b0;
    steps(5);
    check("R5 unstable blocks", int'(actMode), 0);
    check("R8 unstable reason", int'(reason), 2);
    loopStable = 1'b1;
    steps(4);
    check("R5 loop int granted", int'(actMode), 1);

    // Later write of reference select is ignored
    wr(2, 1'b0, 5, 2);
    check("R6 select kept", int'(oscEnable), 1);
    steps(4);
    check("R6 bypass still works", int'(actMode), 2);

    // New reset, first write clears reference select
    rstN = 1'b0;
    steps(2);
    rstN = 1'b1;
    wr(2, 1'b0, 0, 0);
    steps(6);
    check("R6 osc disabled", int'(oscEnable), 0);
    check("R6 ready ignored", int'(actMode), 0);
    check("R8 ref reason locked", int'(reason), 1);
    wr(2, 1'b1, 0, 0);
    steps(6);
    check("R6 second write ignored", int'(oscEnable), 0);
    check("R6 still safe", int'(actMode), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule